// File: doc/BRIEF.md
# Dual-Direction Latched/Registered Bus Transceiver

This block passes data between two buses, called side A and side B, in both directions without inverting it. Each direction has one storage element with three behaviours. It can act as a transparent path, where the far side follows the near side in the same cycle. It can act as a held latch, which keeps its last value. It can act as a register that captures on a falling edge of that direction's data clock, when a clock enable permits it. Each direction also has its own active-low output enable. That enable controls the enable vector of the opposite bus.

Each bus is modelled for synthesis as three vectors: an input, an output and a per-bit output enable. A pad ring or a tristate wrapper turns these into real three-state pins. The block runs on a single system clock. The data clocks and the enables are sampled on that clock. A falling edge of a data clock means the value was sampled high on one system clock edge and low on the next. A synchronous active-high reset puts both output enable vectors in high impedance and clears both stored words.

Top module: `bus_xcvr_univ`

## Requirements
- R1: The data width is the parameter DATA_W (default 18). Every bit is passed without inversion, so bit i of the output equals bit i of the source.
- R2: One system clock after `ab_oe_n` is sampled low, every bit of `b_oe` is 1. One clock after it is sampled high, every bit of `b_oe` is 0. `a_oe` follows `ba_oe_n` in the same way.
- R3: While `ab_le` is high, `b_out` equals `a_in` in the same cycle.
- R4: While `ab_le` is low and no qualifying capture takes place, `b_out` keeps its value from one cycle to the next, whether `ab_cp` is held high or held low.
- R5: A capture takes place when `ab_le` is low and `ab_ce_n` is low, and `ab_cp` is sampled 1 on one clock edge and 0 on the next. The `a_in` value present at that second edge then appears on `b_out` from the following cycle.
- R6: While `ab_ce_n` is high, a falling edge of `ab_cp` leaves the stored word unchanged.
- R7: When `ab_le` goes low, `b_out` holds the `a_in` value sampled at the last clock edge on which `ab_le` was high.
- R8: The B-to-A direction behaves like R3 to R7. It uses `b_in`, `a_out`, `ba_le`, `ba_cp` and `ba_ce_n`.
- R9: The two stored words are independent. Each direction can hold a different value at the same time, and a capture in one direction leaves the other unchanged.
- R10: After a clock edge with `rst` high, `a_oe` and `b_oe` are all zeros and both stored words are zero. The data clock history is also cleared, so the first edge after reset cannot count as a falling edge.
- R11: `a_oe` and `b_oe` must never have bits set at the same time. The checker flags such bus contention.
- R12: The output data vectors always carry the value of their path, whatever the output enable is. The enable vectors alone decide whether that value is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DATA_W | Value seen on bus A |
| a_out | output | DATA_W | Value to drive onto bus A |
| a_oe | output | DATA_W | Per-bit drive enable for bus A |
| b_in | input | DATA_W | Value seen on bus B |
| b_out | output | DATA_W | Value to drive onto bus B |
| b_oe | output | DATA_W | Per-bit drive enable for bus B |
| ab_oe_n | input | 1 | Active-low enable for driving B |
| ab_le | input | 1 | A-to-B transparency control |
| ab_cp | input | 1 | A-to-B data clock, falling edge captures |
| ab_ce_n | input | 1 | Active-low A-to-B capture enable |
| ba_oe_n | input | 1 | Active-low enable for driving A |
| ba_le | input | 1 | B-to-A transparency control |
| ba_cp | input | 1 | B-to-A data clock, falling edge captures |
| ba_ce_n | input | 1 | Active-low B-to-A capture enable |

## Verification
Directed sequences take each direction through its three behaviours. Transparency with a changing source shows same-cycle passing. Holds with the data clock stuck high and stuck low show that a level is never mistaken for an edge. A falling edge with the capture enable on, and then off, shows R5 apart from R6. Falling the transparency control shows what the latch keeps. Loading different words into the two directions and then capturing in one of them shows that they are independent. Random control and data patterns then mix every mode transition against a reference model in the bench. These patterns never enable both sides in the same cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic cp;
        logic ce_n;
    } lane_ctl_t;

    function automatic lane_mode_e pick_mode(input logic le, input logic fall,
                                             input logic ce_n);
        lane_mode_e m;
        if (le)
            m = MODE_PASS;
        else if (fall && !ce_n)
            m = MODE_CAPTURE;
        else
            m = MODE_HOLD;
        return m;
    endfunction

endpackage

// File: rtl/xcvr_fall_detect.sv
module xcvr_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic cp,
    output logic fall
);
    logic cp_q;

    always_ff @(posedge clk) begin
        if (rst)
            cp_q <= 1'b0;
        else
            cp_q <= cp;
    end

    assign fall = cp_q & ~cp;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_mode_e   mode,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (mode != MODE_HOLD)
            q <= d;
    end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         oe_n,
    output logic [W-1:0] oe_vec
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= ~oe_n;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign oe_vec[i] = en_q;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic [W-1:0] dst_oe
);
    logic         fall;
    lane_mode_e   mode;
    logic [W-1:0] held;

    xcvr_fall_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .cp   (ctl.cp),
        .fall (fall)
    );

    assign mode = pick_mode(ctl.le, fall, ctl.ce_n);

    xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .d    (src),
        .q    (held)
    );

    xcvr_drive #(.W(W)) u_drive (
        .clk    (clk),
        .rst    (rst),
        .oe_n   (ctl.oe_n),
        .oe_vec (dst_oe)
    );

    assign dst = (mode == MODE_PASS) ? src : held;
endmodule

// File: rtl/bus_xcvr_univ.sv
module bus_xcvr_univ
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic [DATA_W-1:0] b_oe,
    input  logic              ab_oe_n,
    input  logic              ab_le,
    input  logic              ab_cp,
    input  logic              ab_ce_n,
    input  logic              ba_oe_n,
    input  logic              ba_le,
    input  logic              ba_cp,
    input  logic              ba_ce_n
);
    lane_ctl_t ctl_ab, ctl_ba;

    assign ctl_ab = '{oe_n: ab_oe_n, le: ab_le, cp: ab_cp, ce_n: ab_ce_n};
    assign ctl_ba = '{oe_n: ba_oe_n, le: ba_le, cp: ba_cp, ce_n: ba_ce_n};

    xcvr_lane #(.W(DATA_W)) u_lane_ab (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl_ab),
        .src    (a_in),
        .dst    (b_out),
        .dst_oe (b_oe)
    );

    xcvr_lane #(.W(DATA_W)) u_lane_ba (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl_ba),
        .src    (b_in),
        .dst    (a_out),
        .dst_oe (a_oe)
    );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_cp,
    input logic         ab_ce_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_cp,
    input logic         ba_ce_n
);
    logic rst_q = 1'b0;

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst_q)
            AST_RESET_QUIET: assert (a_oe == '0 && b_oe == '0); // R10
    end

    AST_B_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> b_oe == {W{!$past(ab_oe_n)}}); // R2
    AST_A_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> a_oe == {W{!$past(ba_oe_n)}}); // R2
    AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> b_out == a_in); // R3
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !(!ab_ce_n && !ab_cp && $past(ab_cp)))
        |=> (!ab_le |-> $stable(b_out))); // R4
    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !ab_ce_n && !ab_cp && $past(ab_cp) && !$past(rst))
        |=> (!ab_le |-> b_out == $past(a_in))); // R5
    AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> a_out == b_in); // R8
    AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && !ba_ce_n && !ba_cp && $past(ba_cp) && !$past(rst))
        |=> (!ba_le |-> a_out == $past(b_in))); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !((|a_oe) && (|b_oe))); // R11
endmodule

bind bus_xcvr_univ xcvr_checker #(.W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n)
);

// File: tb/bus_xcvr_univ_bench.sv
module bus_xcvr_univ_bench;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic m_cpab = 1'b0, m_cpba = 1'b0, m_enb = 1'b0, m_ena = 1'b0;

    always #2.5 clk = ~clk;

    bus_xcvr_univ #(.DATA_W(W)) u_bus_xcvr_univ (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n)
    );

    function automatic logic [W-1:0] next_word(logic [W-1:0] cur, logic [W-1:0] d,
                                               logic le, logic cpq, logic cp, logic ce_n);
        if (le) return d;
        if (cpq && !cp && !ce_n) return d;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ab <= '0; m_ba <= '0;
            m_cpab <= 1'b0; m_cpba <= 1'b0;
            m_enb <= 1'b0; m_ena <= 1'b0;
        end else begin
            m_ab <= next_word(m_ab, a_in, ab_le, m_cpab, ab_cp, ab_ce_n);
            m_ba <= next_word(m_ba, b_in, ba_le, m_cpba, ba_cp, ba_ce_n);
            m_cpab <= ab_cp; m_cpba <= ba_cp;
            m_enb <= !ab_oe_n; m_ena <= !ba_oe_n;
        end
    end

    task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "b_out", b_out, ab_le ? a_in : m_ab);
        check(tag, "a_out", a_out, ba_le ? b_in : m_ba);
        check(tag, "b_oe", b_oe, {W{m_enb}});
        check(tag, "a_oe", a_oe, {W{m_ena}});
    endtask

    // drive after a falling clock edge, then compare once settled
    task automatic tick(string tag);
        @(negedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic set_ab(logic oe_n, logic le, logic cp, logic ce_n, logic [W-1:0] d);
        ab_oe_n = oe_n; ab_le = le; ab_cp = cp; ab_ce_n = ce_n; a_in = d;
    endtask

    task automatic set_ba(logic oe_n, logic le, logic cp, logic ce_n, logic [W-1:0] d);
        ba_oe_n = oe_n; ba_le = le; ba_cp = cp; ba_ce_n = ce_n; b_in = d;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset state
        @(negedge clk); @(negedge clk);
        #1;
        check("R10", "b_oe", b_oe, '0);
        check("R10", "a_oe", a_oe, '0);
        check("R10", "b_out", b_out, '0);
        check("R10", "a_out", a_out, '0);
        // R10: data clock high in reset, low right after: no capture on first edge
        @(negedge clk); set_ab(1, 0, 1, 0, 18'h3ffff); set_ba(1, 0, 1, 0, 18'h15555);
        @(negedge clk); rst = 1'b0; set_ab(1, 0, 0, 0, 18'h3ffff); set_ba(1, 0, 0, 0, 18'h15555);
        tick("R10");
        check("R10", "b_out no capture", b_out, '0);

        // R3/R1: transparent pass, non-inverting
        set_ab(0, 1, 0, 1, 18'h2a5c3);
        tick("R3");
        check("R1", "b_out passthrough", b_out, 18'h2a5c3);
        a_in = 18'h1035f;
        #1 check("R3", "b_out same cycle", b_out, 18'h1035f);
        tick("R2");
        check("R2", "b_oe enabled", b_oe, '1);

        // R7: le falls, keeps last transparent value
        set_ab(0, 0, 0, 1, 18'h00fff);
        tick("R7");
        check("R7", "b_out latched", b_out, 18'h1035f);

        // R4: clock held high, then held low
        ab_cp = 1'b1; tick("R4"); tick("R4");
        check("R4", "b_out hold cp high", b_out, 18'h1035f);
        ab_ce_n = 1'b0;                  // still high: no edge yet
        tick("R4");
        check("R4", "b_out hold cp high ce", b_out, 18'h1035f);

        // R6: falling edge with capture disabled
        set_ab(0, 0, 0, 1, 18'h0beef);
        tick("R6"); tick("R6");
        check("R6", "b_out ignored edge", b_out, 18'h1035f);

        // R5: qualified falling edge captures
        set_ab(0, 0, 1, 0, 18'h0beef); tick("R5");
        set_ab(0, 0, 0, 0, 18'h2c0de); tick("R5");
        a_in = 18'h11111; tick("R5");
        check("R5", "b_out captured", b_out, 18'h2c0de);
        tick("R4");
        check("R4", "b_out hold cp low", b_out, 18'h2c0de);

        // R8/R9: load B-to-A with a different word, then capture in A-to-B only
        set_ab(1, 0, 0, 1, 18'h0); set_ba(1, 1, 0, 1, 18'h0abcd); tick("R8");
        check("R8", "a_out passthrough", a_out, 18'h0abcd);
        set_ba(0, 0, 0, 1, 18'h3fff0); tick("R8");
        check("R8", "a_out latched", a_out, 18'h0abcd);
        set_ab(1, 0, 1, 0, 18'h01234); tick("R9");
        ab_cp = 1'b0; tick("R9"); tick("R9");
        check("R9", "b_out new", b_out, 18'h01234);
        check("R9", "a_out unchanged", a_out, 18'h0abcd);
        check("R2", "a_oe enabled", a_oe, '1);
        check("R12", "b_out carried while off", b_out, 18'h01234);
        check("R2", "b_oe off", b_oe, '0);

        // random mix, never both sides enabled
        for (int i = 0; i < 3000; i++) begin
            int unsigned sel;
            sel = $urandom_range(0, 2);
            set_ab(!(sel == 1), ($urandom_range(0, 5) == 0), $urandom_range(0, 1),
                   $urandom_range(0, 1), W'($urandom()));
            set_ba(!(sel == 2), ($urandom_range(0, 5) == 0), $urandom_range(0, 1),
                   $urandom_range(0, 1), W'($urandom()));
            #1;
            tick("R12");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule